// File: doc/BRIEF.md
# Multiplexed seven-segment scan driver

This block refreshes an eight-digit multiplexed seven-segment LED display from an external 8-entry by 8-bit display memory. It steps a scan index through the digits. For each digit it places the index on a read-address port and takes the returned byte from the memory. It drives one digit strobe together with eight segment lines: a to g plus the decimal point.

Each byte can be shown in one of three ways. It can drive the segments directly, with its own bit-to-segment order. It can be decoded from its low nibble as a hexadecimal character. It can be decoded from its low nibble through a second character set that holds the digits, a minus sign, E, H, L, P and blank. A dark gap of a set number of clock cycles separates consecutive strobes, so the segment lines settle before the next digit turns on.

A shutdown input turns every output off and freezes the scan. The memory is not part of this block, so it can still be written during shutdown. When shutdown is released, the scan resumes where it stopped. One parameter inverts all outputs together, for common-anode or common-cathode displays.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is high, and in the cycle after it, every digit and segment output is inactive and the read address is 0. The first strobe after reset is digit 0, whatever digit was lit before reset.
- R2: Digits are strobed in the order 0,1,…,7 and then back to 0. Digit k raises bit k of the strobe bus and no other bit. In the first lit cycle of digit k the read address equals k. Each strobe stays lit for DIGIT_CYCLES−BLANK_CYCLES cycles.
- R3: Between any two consecutive strobes there are exactly BLANK_CYCLES cycles in which all digit and segment outputs are inactive. A strobe never changes directly into another strobe.
- R4: With decode on and hexadecimal selected, nibble values 0–F give the segment codes (bits g..a) 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. Segment output bit 0 is a, bits 1 to 6 are b to g, and bit 7 is the decimal point.
- R5: With decode on and the second set selected, nibble values 0–9 give the same codes as in R4. The remaining values give these codes: 10 → 40 (minus), 11 → 79 (E), 12 → 76 (H), 13 → 38 (L), 14 → 73 (P), 15 → 00 (blank).
- R6: With decode off, the byte drives the segments directly. Byte bit 6 drives a, bit 5 drives b, bit 4 drives c, bit 3 drives e, bit 2 drives g, bit 1 drives f and bit 0 drives d.
- R7: With decode off, the decimal point is lit when byte bit 7 is 0. With decode on, it is lit when bit 7 is 1, and byte bits 6 to 4 have no effect on the output.
- R8: From the cycle after shutdown rises, all outputs are inactive and the scan position holds. When shutdown falls, the digit that was interrupted lights again at once. It shows whatever the memory holds at that time, including data written during shutdown.
- R9: With ACTIVE_LOW set, every digit and segment output is the bitwise inverse of the output the same block gives with ACTIVE_LOW clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| dec_en_i | input | 1 | 1: decode the low nibble; 0: drive segments directly |
| hex_sel_i | input | 1 | in decode: 1 selects hexadecimal, 0 selects the second character set |
| shut_i | input | 1 | shutdown: outputs off, scan frozen |
| rd_addr_o | output | 3 | display memory read address (digit index) |
| rd_data_i | input | 8 | byte read from the display memory, combinational |
| dig_o | output | 8 | digit strobes, bit k for digit k |
| seg_o | output | 8 | segments, bit 0 = a … bit 6 = g, bit 7 = decimal point |

## Verification
The risky coincidence is shutdown arriving while a strobe is lit. Three things then fall in the same cycle: the output gating, the scan freeze and a change of display data. The bench raises shutdown in the middle of a lit digit and checks that the outputs go dark on the next cycle. It rewrites every memory byte while shutdown is held. After release, it expects the same digit back immediately, showing the new glyph, with no gap inserted and no digit skipped. A second case resets the block in the middle of a scan and checks that the next strobe is digit 0 and not the next digit in sequence.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    // Segment vector, bit 0 = a ... bit 6 = g, bit 7 = decimal point.
    typedef struct packed {
        logic dp;
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_t;

    typedef enum logic [1:0] {
        MODE_RAW = 2'd0,
        MODE_HEX = 2'd1,
        MODE_ALT = 2'd2
    } dec_mode_e;

    // Hexadecimal glyphs, returned as g..a.
    function automatic logic [6:0] hex_glyph(input logic [3:0] n);
        logic [6:0] r;
        case (n)
            4'h0: r = 7'h3F;
            4'h1: r = 7'h06;
            4'h2: r = 7'h5B;
            4'h3: r = 7'h4F;
            4'h4: r = 7'h66;
            4'h5: r = 7'h6D;
            4'h6: r = 7'h7D;
            4'h7: r = 7'h07;
            4'h8: r = 7'h7F;
            4'h9: r = 7'h6F;
            4'hA: r = 7'h77;
            4'hB: r = 7'h7C;
            4'hC: r = 7'h39;
            4'hD: r = 7'h5E;
            4'hE: r = 7'h79;
            default: r = 7'h71;
        endcase
        return r;
    endfunction

    // Second character set: numerals, then minus, E, H, L, P, blank.
    function automatic logic [6:0] alt_glyph(input logic [3:0] n);
        logic [6:0] r;
        case (n)
            4'hA: r = 7'h40;
            4'hB: r = 7'h79;
            4'hC: r = 7'h76;
            4'hD: r = 7'h38;
            4'hE: r = 7'h73;
            4'hF: r = 7'h00;
            default: r = hex_glyph(n);
        endcase
        return r;
    endfunction

    // Direct drive: fixed bit permutation, decimal point lit by a zero.
    function automatic seg_t raw_map(input logic [7:0] b);
        seg_t r;
        r.dp = ~b[7];
        r.a  = b[6];
        r.b  = b[5];
        r.c  = b[4];
        r.e  = b[3];
        r.g  = b[2];
        r.f  = b[1];
        r.d  = b[0];
        return r;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int DIGITS       = 8,
    parameter int DIGIT_CYCLES = 50000,
    parameter int BLANK_CYCLES = 1000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hold_i,
    output logic [$clog2(DIGITS)-1:0] idx_o,
    output logic                      blank_o
);
    localparam int TW = $clog2(DIGIT_CYCLES);
    localparam int IW = $clog2(DIGITS);
    localparam logic [TW-1:0] TICK_LAST = TW'(DIGIT_CYCLES - 1);
    localparam logic [TW-1:0] TICK_LIT  = TW'(BLANK_CYCLES);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DIGITS - 1);

    logic [TW-1:0] tick_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            idx_q  <= '0;
        end else if (!hold_i) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                idx_q  <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign idx_o   = idx_q;
    assign blank_o = (tick_q < TICK_LIT);

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> ($stable(tick_q) && $stable(idx_q)));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && tick_q == TICK_LAST) |=>
            (idx_q == (($past(idx_q) == IDX_LAST) ? '0 : IW'($past(idx_q) + 1'b1))));

    // R2
    dwell_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q != TICK_LAST) |=> $stable(idx_q));

endmodule

// File: rtl/glyph_decoder.sv
module glyph_decoder
    import seg_scan_pkg::*;
(
    input  dec_mode_e  mode_i,
    input  logic [7:0] byte_i,
    output seg_t       seg_o
);
    always_comb begin
        unique case (mode_i)
            MODE_HEX: seg_o = {byte_i[7], hex_glyph(byte_i[3:0])};
            MODE_ALT: seg_o = {byte_i[7], alt_glyph(byte_i[3:0])};
            default:  seg_o = raw_map(byte_i);
        endcase
    end
endmodule

// File: rtl/drive_stage.sv
module drive_stage
    import seg_scan_pkg::*;
#(
    parameter int DIGITS     = 8,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      off_i,
    input  logic                      blank_i,
    input  logic [$clog2(DIGITS)-1:0] idx_i,
    input  seg_t                      seg_i,
    output logic [DIGITS-1:0]         dig_o,
    output logic [7:0]                seg_o
);
    logic [DIGITS-1:0] dig_nx;
    logic [DIGITS-1:0] dig_act_q;
    seg_t              seg_act_q;

    always_comb begin
        dig_nx        = '0;
        dig_nx[idx_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || off_i || blank_i) begin
            dig_act_q <= '0;
            seg_act_q <= '0;
        end else begin
            dig_act_q <= dig_nx;
            seg_act_q <= seg_i;
        end
    end

    generate
        if (ACTIVE_LOW) begin : g_inv
            assign dig_o = ~dig_act_q;
            assign seg_o = ~seg_act_q;
        end else begin : g_pass
            assign dig_o = dig_act_q;
            assign seg_o = seg_act_q;
        end
    endgenerate

    // R2
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_act_q));

    // R3
    gap_chk: assert property (@(posedge clk) disable iff (rst)
        (dig_act_q != '0) |=> (dig_act_q == '0 || dig_act_q == $past(dig_act_q)));

    // R3
    dark_chk: assert property (@(posedge clk) disable iff (rst)
        (dig_act_q == '0) |-> (seg_act_q == '0));

    // R8
    shut_off_chk: assert property (@(posedge clk) disable iff (rst)
        off_i |=> (dig_act_q == '0 && seg_act_q == '0));

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
    import seg_scan_pkg::*;
#(
    parameter int DIGITS       = 8,
    parameter int DIGIT_CYCLES = 50000,
    parameter int BLANK_CYCLES = 1000,
    parameter bit ACTIVE_LOW   = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dec_en_i,
    input  logic                      hex_sel_i,
    input  logic                      shut_i,
    output logic [$clog2(DIGITS)-1:0] rd_addr_o,
    input  logic [7:0]                rd_data_i,
    output logic [DIGITS-1:0]         dig_o,
    output logic [7:0]                seg_o
);
    localparam int IW = $clog2(DIGITS);

    logic [IW-1:0] idx;
    logic          blank;
    dec_mode_e     mode;
    seg_t          glyph;

    assign mode = !dec_en_i ? MODE_RAW : (hex_sel_i ? MODE_HEX : MODE_ALT);

    scan_timer #(
        .DIGITS(DIGITS), .DIGIT_CYCLES(DIGIT_CYCLES), .BLANK_CYCLES(BLANK_CYCLES)
    ) u_timer (
        .clk(clk), .rst(rst), .hold_i(shut_i), .idx_o(idx), .blank_o(blank)
    );

    assign rd_addr_o = idx;

    glyph_decoder u_dec (
        .mode_i(mode), .byte_i(rd_data_i), .seg_o(glyph)
    );

    drive_stage #(
        .DIGITS(DIGITS), .ACTIVE_LOW(ACTIVE_LOW)
    ) u_drv (
        .clk(clk), .rst(rst), .off_i(shut_i), .blank_i(blank),
        .idx_i(idx), .seg_i(glyph), .dig_o(dig_o), .seg_o(seg_o)
    );
endmodule

// File: tb/tb_seg_scan_driver.sv
module tb_seg_scan_driver;
    localparam int P = 20;
    localparam int B = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_en = 1'b1, hex_sel = 1'b1, shut = 1'b0;
    logic [7:0] mem [8];
    logic [2:0] addr_a, addr_b;
    logic [7:0] dig_a, dig_b, seg_a, seg_b;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    seg_scan_driver #(.DIGIT_CYCLES(P), .BLANK_CYCLES(B), .ACTIVE_LOW(1'b0)) dut (
        .clk(clk), .rst(rst), .dec_en_i(dec_en), .hex_sel_i(hex_sel), .shut_i(shut),
        .rd_addr_o(addr_a), .rd_data_i(mem[addr_a]), .dig_o(dig_a), .seg_o(seg_a));

    seg_scan_driver #(.DIGIT_CYCLES(P), .BLANK_CYCLES(B), .ACTIVE_LOW(1'b1)) dut_n (
        .clk(clk), .rst(rst), .dec_en_i(dec_en), .hex_sel_i(hex_sel), .shut_i(shut),
        .rd_addr_o(addr_b), .rd_data_i(mem[addr_b]), .dig_o(dig_b), .seg_o(seg_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R9: inverted instance mirrors the true-polarity one
    task automatic chk_pol();
        chk("R9 dig", {24'h0, dig_b}, {24'h0, ~dig_a});
        chk("R9 seg", {24'h0, seg_b}, {24'h0, ~seg_a});
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 8; i++) mem[i] = v;
    endtask

    // Wait for the start of a fresh strobe; returns at the negedge of its first lit cycle.
    task automatic next_strobe();
        do @(negedge clk); while (dig_a != 8'h00);
        do @(negedge clk); while (dig_a == 8'h00);
    endtask

    typedef struct packed {
        logic       dec;
        logic       hex;
        logic [7:0] dat;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R4 hexadecimal glyphs
        '{1'b1, 1'b1, 8'h00, 8'h3F, 4'd4},
        '{1'b1, 1'b1, 8'h0A, 8'h77, 4'd4},
        '{1'b1, 1'b1, 8'h0B, 8'h7C, 4'd4},
        '{1'b1, 1'b1, 8'h0F, 8'h71, 4'd4},
        '{1'b1, 1'b1, 8'h06, 8'h7D, 4'd4},
        // R7 decimal point high-true in decode, bits 6:4 ignored
        '{1'b1, 1'b1, 8'h8B, 8'hFC, 4'd7},
        '{1'b1, 1'b1, 8'h7D, 8'h5E, 4'd7},
        // R5 second character set
        '{1'b1, 1'b0, 8'h0A, 8'h40, 4'd5},
        '{1'b1, 1'b0, 8'h0B, 8'h79, 4'd5},
        '{1'b1, 1'b0, 8'h0C, 8'h76, 4'd5},
        '{1'b1, 1'b0, 8'h0D, 8'h38, 4'd5},
        '{1'b1, 1'b0, 8'h0E, 8'h73, 4'd5},
        '{1'b1, 1'b0, 8'h0F, 8'h00, 4'd5},
        '{1'b1, 1'b0, 8'h09, 8'h6F, 4'd5},
        '{1'b1, 1'b0, 8'h8F, 8'h80, 4'd7},
        // R6 direct drive permutation
        '{1'b0, 1'b0, 8'h40, 8'h81, 4'd6},
        '{1'b0, 1'b0, 8'h3F, 8'hFE, 4'd6},
        '{1'b0, 1'b1, 8'hA4, 8'h42, 4'd6},
        '{1'b0, 1'b0, 8'h14, 8'hC4, 4'd6},
        '{1'b0, 1'b1, 8'h01, 8'h88, 4'd6},
        // R7 decimal point low-true in direct drive
        '{1'b0, 1'b0, 8'h80, 8'h00, 4'd7},
        '{1'b0, 1'b0, 8'h00, 8'h80, 4'd7}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lit, dark, k;
        fill(8'h00);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 dig", {24'h0, dig_a}, 32'h0);
        chk("R1 seg", {24'h0, seg_a}, 32'h0);
        chk("R1 addr", {29'h0, addr_a}, 32'h0);
        chk_pol();
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dig after release", {24'h0, dig_a}, 32'h0);

        // R2 scan order and read address, with a wrap
        for (int i = 0; i < 10; i++) begin
            next_strobe();
            chk("R2 strobe", {24'h0, dig_a}, 32'h1 << (i % 8));
            chk("R2 addr", {29'h0, addr_a}, i % 8);
        end

        // R2 lit length, R3 gap length
        next_strobe();
        lit = 0;
        while (dig_a != 8'h00) begin lit++; @(negedge clk); end
        dark = 0;
        while (dig_a == 8'h00) begin
            dark++;
            chk("R3 dark seg", {24'h0, seg_a}, 32'h0);
            @(negedge clk);
        end
        chk("R2 lit length", lit, P - B);
        chk("R3 gap length", dark, B);

        // Table walk: R4 R5 R6 R7, each with R9 polarity
        for (int v = 0; v < NV; v++) begin
            do @(negedge clk); while (dig_a != 8'h00);
            dec_en  = VECS[v].dec;
            hex_sel = VECS[v].hex;
            fill(VECS[v].dat);
            do @(negedge clk); while (dig_a == 8'h00);
            chk($sformatf("R%0d vector %0d", VECS[v].req, v), {24'h0, seg_a}, {24'h0, VECS[v].exp});
            chk_pol();
        end

        // R8 shutdown mid-strobe, rewrite memory, release
        dec_en = 1'b1; hex_sel = 1'b1; fill(8'h03);
        next_strobe();
        repeat (3) @(negedge clk);
        k = 0;
        for (int i = 0; i < 8; i++) if (dig_a[i]) k = i;
        shut = 1'b1;
        @(negedge clk);
        chk("R8 dig off", {24'h0, dig_a}, 32'h0);
        chk("R8 seg off", {24'h0, seg_a}, 32'h0);
        chk_pol();
        fill(8'h8E);
        repeat (50) @(negedge clk);
        chk("R8 still off", {24'h0, dig_a}, 32'h0);
        shut = 1'b0;
        @(negedge clk);
        chk("R8 same digit", {24'h0, dig_a}, 32'h1 << k);
        chk("R8 new data", {24'h0, seg_a}, 32'hF9);

        // R1 reset mid-scan restarts at digit 0
        next_strobe();
        next_strobe();
        next_strobe();
        rst = 1'b1;
        @(negedge clk);
        chk("R1 dig in reset", {24'h0, dig_a}, 32'h0);
        rst = 1'b0;
        next_strobe();
        chk("R1 restart digit", {24'h0, dig_a}, 32'h1);
        chk_pol();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule